// File: doc/BRIEF.md
# Byte-Lane Parity Checker and Generator

This block holds the parity logic for one 36-bit port. The port is divided into four 9-bit lanes. In each lane the upper bit is the parity bit and the lower eight bits are data. Every lane arriving on the port is checked against a selectable parity sense, either odd or even. If any lane fails, a registered active-low error flag goes low on the next clock.

On the way out, the block passes mailbox register data to the port. When a parity-generating mailbox read is set up, it rewrites the top bit of each lane with parity computed over that lane's eight data bits. One set of parity trees serves both jobs. In the generating mode the trees are steered to the mailbox data, so the port check cannot run, and the error flag is held inactive.

The storage arrays that feed the mailbox data lie outside this block.

Top module: `lane_parity_unit`

## Requirements
- R1: Lane k (k = 0..3) covers bits 9k to 9k+8. Bit 9k+8 is that lane's parity bit and bits 9k..9k+7 are its data.
- R2: With `oddSel` high, a lane passes its check when its nine bits hold an odd number of ones.
- R3: With `oddSel` low, a lane passes its check when its nine bits hold an even number of ones.
- R4: `parityErrN` is registered. After a rising edge it is low if any single lane of `portIn` sampled at that edge failed, and high if all four lanes passed.
- R5: While `rstN` is low, `parityErrN` is high.
- R6: Generate mode is active exactly when all five of these hold: `chipSelN` low, `enable` high, `dirWrite` low, `mailSel` high and `genEnable` high. In generate mode, bit 9k+8 of `portOut` is set so that lane k of `portOut` holds an odd (when `oddSel` is high) or even (when `oddSel` is low) number of ones.
- R7: In generate mode, bits 9k..9k+7 of `portOut` equal the same bits of `mailData`.
- R8: In generate mode, `parityErrN` is high after the next rising edge, whatever `portIn` carries.
- R9: When any one of the five generate-mode conditions is false, `portOut` equals `mailData` unchanged, and `portIn` is checked as in R2 to R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chipSelN | input | 1 | Port select, active low |
| enable | input | 1 | Port transfer enable, active high |
| dirWrite | input | 1 | 1 = data into the port, 0 = read out of the port |
| mailSel | input | 1 | Selects the mailbox register for the transfer |
| genEnable | input | 1 | Requests parity generation on mailbox reads |
| oddSel | input | 1 | 1 = odd parity sense, 0 = even |
| portIn | input | 36 | Data arriving on the port, four 9-bit lanes |
| mailData | input | 36 | Mailbox register contents to be driven out |
| portOut | output | 36 | Outgoing port data, with generated parity when enabled |
| parityErrN | output | 1 | Registered parity error flag, active low |

## Verification
A single corrupted lane is placed in each of the four positions, under both parity senses. A design that split the lanes at the wrong place, or that combined the lane results with AND instead of OR, would miss some of these lanes.

Generate mode is driven with port data in which every lane is bad. A design that did not release the shared trees from checking would pull the flag low. A design that computed generated parity with the wrong sense would emit lanes that fail their own check.

Each of the five mode conditions is then removed one at a time. An incomplete decode would rewrite mailbox bits when it should not, or would stop checking real errors.

// File: rtl/lane_parity_pkg.sv
package lane_parity_pkg;
  // Strobes passed from control to the datapath.
  typedef struct packed {
    logic genMode;   // trees steered to mailbox data, top bits rewritten
    logic oddSense;  // 1 = odd parity sense
  } parStrobe_t;
endpackage

// File: rtl/lane_parity_dp.sv
module lane_parity_dp
  import lane_parity_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  parStrobe_t               strobe,
  input  logic [LANES*LANE_W-1:0]  portIn,
  input  logic [LANES*LANE_W-1:0]  mailData,
  output logic [LANES*LANE_W-1:0]  portOut,
  output logic [LANES-1:0]         laneFail
);
  localparam int DATA_W = LANE_W - 1;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    localparam int LO = g * LANE_W;
    logic [LANE_W-1:0] treeIn;
    logic              treeX;
    logic              senseMiss;

    // One tree per lane: the port lane when checking, the mailbox data bits when generating.
    always_comb begin
      if (strobe.genMode) treeIn = {1'b0, mailData[LO +: DATA_W]};
      else                treeIn = portIn[LO +: LANE_W];
    end

    assign treeX     = ^treeIn;
    // When checking, the lane fails on a mismatch with the sense.
    // When generating, the same value is the parity bit to emit.
    assign senseMiss = treeX ^ strobe.oddSense;
    assign laneFail[g] = senseMiss;

    always_comb begin
      if (strobe.genMode) portOut[LO +: LANE_W] = {senseMiss, mailData[LO +: DATA_W]};
      else                portOut[LO +: LANE_W] = mailData[LO +: LANE_W];
    end
  end
endmodule

// File: rtl/lane_parity_ctrl.sv
module lane_parity_ctrl
  import lane_parity_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chipSelN,
  input  logic             enable,
  input  logic             dirWrite,
  input  logic             mailSel,
  input  logic             genEnable,
  input  logic             oddSel,
  input  logic [LANES-1:0] laneFail,
  output parStrobe_t       strobe,
  output logic             parityErrN
);
  logic genQual;

  assign genQual = ~chipSelN & enable & ~dirWrite & mailSel & genEnable;

  always_comb begin
    strobe.genMode  = genQual;
    strobe.oddSense = oddSel;
  end

  // In generate mode the trees are busy with mailbox data, so the flag is held inactive.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) parityErrN <= 1'b1;
    else       parityErrN <= genQual | ~(|laneFail);
  end
endmodule

// File: rtl/lane_parity_unit.sv
module lane_parity_unit
  import lane_parity_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     chipSelN,
  input  logic                     enable,
  input  logic                     dirWrite,
  input  logic                     mailSel,
  input  logic                     genEnable,
  input  logic                     oddSel,
  input  logic [LANES*LANE_W-1:0]  portIn,
  input  logic [LANES*LANE_W-1:0]  mailData,
  output logic [LANES*LANE_W-1:0]  portOut,
  output logic                     parityErrN
);
  parStrobe_t       strobe;
  logic [LANES-1:0] laneFail;

  lane_parity_ctrl #(.LANES(LANES)) u_ctrl (
    .clk(clk), .rstN(rstN), .chipSelN(chipSelN), .enable(enable),
    .dirWrite(dirWrite), .mailSel(mailSel), .genEnable(genEnable),
    .oddSel(oddSel), .laneFail(laneFail), .strobe(strobe),
    .parityErrN(parityErrN)
  );

  lane_parity_dp #(.LANES(LANES), .LANE_W(LANE_W)) u_dp (
    .strobe(strobe), .portIn(portIn), .mailData(mailData),
    .portOut(portOut), .laneFail(laneFail)
  );
endmodule

// File: rtl/lane_parity_chk.sv
module lane_parity_chk #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     chipSelN,
  input logic                     enable,
  input logic                     dirWrite,
  input logic                     mailSel,
  input logic                     genEnable,
  input logic                     oddSel,
  input logic [LANES*LANE_W-1:0]  portIn,
  input logic [LANES*LANE_W-1:0]  mailData,
  input logic [LANES*LANE_W-1:0]  portOut,
  input logic                     parityErrN
);
  localparam int DATA_W = LANE_W - 1;

  logic             modeOn;
  logic [LANES-1:0] laneOk;

  assign modeOn = !chipSelN && enable && !dirWrite && mailSel && genEnable;

  for (genvar g = 0; g < LANES; g++) begin : gChk
    assign laneOk[g] = ((^portIn[g*LANE_W +: LANE_W]) == oddSel);

    // R6: every generated lane satisfies the selected sense.
    assert_gen_parity_R6: assert property (@(posedge clk) disable iff (!rstN)
      modeOn |-> ((^portOut[g*LANE_W +: LANE_W]) == oddSel));

    // R7: data bits pass through in generate mode.
    assert_gen_passthru_R7: assert property (@(posedge clk) disable iff (!rstN)
      modeOn |-> (portOut[g*LANE_W +: DATA_W] == mailData[g*LANE_W +: DATA_W]));
  end

  // R5: flag is inactive while reset is held.
  always @(negedge clk) begin
    if (!rstN) assert_reset_flag_R5: assert (parityErrN);
  end

  // R8: generate mode forces the flag high.
  assert_gen_flag_high_R8: assert property (@(posedge clk) disable iff (!rstN)
    modeOn |=> parityErrN);

  // R4: a failing lane outside generate mode drives the flag low.
  assert_err_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!modeOn && !(&laneOk)) |=> !parityErrN);

  // R4: all lanes passing outside generate mode leaves the flag high.
  assert_err_high_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!modeOn && (&laneOk)) |=> parityErrN);

  // R9: outside generate mode the mailbox data is not altered.
  assert_nogen_copy_R9: assert property (@(posedge clk) disable iff (!rstN)
    !modeOn |-> (portOut == mailData));
endmodule

bind lane_parity_unit lane_parity_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk(clk), .rstN(rstN), .chipSelN(chipSelN), .enable(enable),
  .dirWrite(dirWrite), .mailSel(mailSel), .genEnable(genEnable),
  .oddSel(oddSel), .portIn(portIn), .mailData(mailData),
  .portOut(portOut), .parityErrN(parityErrN)
);

// File: tb/lane_parity_unit_bench.sv
`timescale 1ns/1ps
module lane_parity_unit_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        chipSelN, enable, dirWrite, mailSel, genEnable, oddSel;
  logic [35:0] portIn, mailData, portOut;
  logic        parityErrN;

  int checks = 0;
  int errors = 0;
  bit doneFlag = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  lane_parity_unit u_lane_parity_unit (
    .clk(clk), .rstN(rstN), .chipSelN(chipSelN), .enable(enable),
    .dirWrite(dirWrite), .mailSel(mailSel), .genEnable(genEnable),
    .oddSel(oddSel), .portIn(portIn), .mailData(mailData),
    .portOut(portOut), .parityErrN(parityErrN)
  );

  // Build one 9-bit lane from data. good=1 gives correct parity for the sense.
  function automatic logic [8:0] mkLane(logic [7:0] d, logic odd, logic good);
    logic p;
    p = (^d) ^ odd;  // bit that makes the nine-bit count match the sense
    return {good ? p : ~p, d};
  endfunction

  // Four lanes with data seeded by base. Lanes whose bit in badMask is set get wrong parity.
  function automatic logic [35:0] mkWord(logic [7:0] base, logic odd, logic [3:0] badMask);
    logic [35:0] w;
    for (int k = 0; k < 4; k++)
      w[k*9 +: 9] = mkLane(base + 8'(k * 37), odd, !badMask[k]);
    return w;
  endfunction

  task automatic check(bit ok, string req, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idleCtl();
    chipSelN = 1'b1; enable = 1'b0; dirWrite = 1'b1;
    mailSel = 1'b0; genEnable = 1'b0;
  endtask

  task automatic genCtl();
    chipSelN = 1'b0; enable = 1'b1; dirWrite = 1'b0;
    mailSel = 1'b1; genEnable = 1'b1;
  endtask

  // Drive at the falling edge, let one rising edge capture, sample at the next falling edge.
  task automatic applyStep(logic [35:0] pin);
    @(negedge clk);
    portIn = pin;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rstN = 1'b0; idleCtl(); oddSel = 1'b1;
    portIn = mkWord(8'h11, 1'b1, 4'hF); mailData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(parityErrN == 1'b1, "R5 reset flag", {35'd0, parityErrN}, 36'd1);
    rstN = 1'b1;
  endtask

  task automatic t_clean(logic odd);
    idleCtl(); oddSel = odd;
    applyStep(mkWord(8'h5A, odd, 4'h0));
    check(parityErrN == 1'b1, odd ? "R2 odd clean" : "R3 even clean", {35'd0, parityErrN}, 36'd1);
    // Zero data: the even sense needs a clear top bit, the odd sense a set one.
    applyStep(mkWord(8'h00, odd, 4'h0));
    check(parityErrN == 1'b1, odd ? "R2 odd zero data" : "R3 even zero data", {35'd0, parityErrN}, 36'd1);
  endtask

  task automatic t_singleLane(logic odd);
    idleCtl(); oddSel = odd;
    for (int k = 0; k < 4; k++) begin
      applyStep(mkWord(8'hC3 + 8'(k), odd, 4'(1 << k)));
      check(parityErrN == 1'b0, "R1 R4 single bad lane", {35'd0, parityErrN}, 36'd0);
      applyStep(mkWord(8'hC3 + 8'(k), odd, 4'h0));
      check(parityErrN == 1'b1, "R4 flag recovers", {35'd0, parityErrN}, 36'd1);
    end
  endtask

  task automatic t_wrongSense();
    // Lanes built for even parity and checked as odd: all four fail.
    idleCtl(); oddSel = 1'b1;
    applyStep(mkWord(8'h3C, 1'b0, 4'h0));
    check(parityErrN == 1'b0, "R2 even data under odd sense", {35'd0, parityErrN}, 36'd0);
  endtask

  task automatic t_gen(logic odd);
    logic [35:0] exp;
    genCtl(); oddSel = odd;
    mailData = 36'hA_5C3_9E71;
    exp = '0;
    for (int k = 0; k < 4; k++)
      exp[k*9 +: 9] = mkLane(mailData[k*9 +: 8], odd, 1'b1);
    applyStep(mkWord(8'h77, odd, 4'hF));
    check(portOut == exp, odd ? "R6 R7 gen odd output" : "R6 R7 gen even output", portOut, exp);
    check(parityErrN == 1'b1, "R8 flag forced high", {35'd0, parityErrN}, 36'd1);
    mailData = 36'hF_FFFF_FFFF;
    exp = '0;
    for (int k = 0; k < 4; k++)
      exp[k*9 +: 9] = mkLane(8'hFF, odd, 1'b1);
    #0.1;
    check(portOut == exp, "R6 gen all ones", portOut, exp);
  endtask

  task automatic t_qualifiers();
    for (int q = 0; q < 5; q++) begin
      genCtl(); oddSel = 1'b1;
      case (q)
        0: chipSelN  = 1'b1;
        1: enable    = 1'b0;
        2: dirWrite  = 1'b1;
        3: mailSel   = 1'b0;
        default: genEnable = 1'b0;
      endcase
      mailData = 36'h1_2345_6789 ^ 36'(q);
      applyStep(mkWord(8'h21, 1'b1, 4'h4));
      check(portOut == mailData, "R9 no rewrite with one qualifier off", portOut, mailData);
      check(parityErrN == 1'b0, "R9 checking stays active", {35'd0, parityErrN}, 36'd0);
    end
  endtask

  initial begin
    #200000;
    if (!doneFlag) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_clean(1'b1);
    t_clean(1'b0);
    t_singleLane(1'b1);
    t_singleLane(1'b0);
    t_wrongSense();
    t_gen(1'b1);
    t_gen(1'b0);
    t_qualifiers();
    doneFlag = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule